// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

The controller gathers a set of peripheral interrupt lines and offers a single request, with the identity of the chosen source, to a processor. Each line is edge sensitive. A rising edge makes its source pending, and the pending flag stays set until the processor acknowledges that source. The processor accepts an offer with a one-cycle acknowledge. It reports that a handler has finished with a one-cycle end-of-service strobe.

Two handling policies can be selected at run time. In sequential mode the controller offers nothing while a source is in service. Sources that become pending during that time are queued in the order they arrived, and priority plays no part. In nested mode every source has a fixed urgency level. A pending source with a strictly higher level than the one in service is offered at once. The handlers in service sit on a stack, so each end-of-service strobe resumes the source that was interrupted. The policy select is expected to change only while nothing is pending or in service.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` and `active_valid` are low.
- R2: A source becomes pending one clock after a rising edge on its line. A line held high does not make the source pending again once it has been acknowledged.
- R3: An acknowledge taken while `irq_req` is high pushes the offered `irq_id` into service. In the next cycle `active_valid` is high, `active_id` equals that id, and the source is no longer pending.
- R4: With `mode_nested` = 0 (sequential), `irq_req` stays low while any source is in service.
- R5: In sequential mode, pending sources are offered in order of arrival and priority is ignored. Edges that arrive in the same cycle are queued lowest index first.
- R6: In sequential mode, a further rising edge on a source that is already pending adds no second queue entry, so the source is served once.
- R7: With `mode_nested` = 1 (nested), a pending source whose level is strictly above the level in service is offered while the other source is still in service.
- R8: In nested mode, a pending source whose level is lower than or equal to the level in service is not offered.
- R9: `svc_done` ends the source on top of the service stack. `active_id` then shows the source it had preempted, or `active_valid` falls when the stack becomes empty.
- R10: The default levels are 2 for source 0, 4 for source 1 and 5 for source 2, and a larger number is more urgent. When nothing is in service in nested mode, the pending source with the highest level is offered.
- R11: An acknowledge while `irq_req` is low, or a `svc_done` while nothing is in service, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | N_SRC | Interrupt lines from the peripherals, edge sensitive |
| mode_nested | input | 1 | 1 selects nested priority handling, 0 selects sequential handling |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | IDW | Source offered with `irq_req` |
| irq_ack | input | 1 | Processor accepts the offered source |
| svc_done | input | 1 | The current handler has finished |
| active_valid | output | 1 | A source is in service |
| active_id | output | IDW | Source at the top of the service stack |

## Verification
The bench uses the default build: three sources with the distinct levels 2, 4 and 5. With three distinct levels, nested mode can fill the service stack to its full depth of three. The bench then unwinds the stack one entry at a time, and it checks that a source of equal level waits. Because the level order differs from the index order, a sequential-mode test can set arrival order against priority and show that arrival order decides.

// File: rtl/irq_pkg.sv
// Shared definitions for the interrupt controller.
// Assumes: it is compiled before every module that imports it.
package irq_pkg;
    typedef enum logic {
        POL_SEQ  = 1'b0,
        POL_NEST = 1'b1
    } irq_policy_e;
endpackage

// File: rtl/irq_edge_pend.sv
// Rising-edge detection and pending flags, one per source line.
// Assumes: the request lines are already synchronous to clk.
// A new edge wins over a clear aimed at the same source in the same cycle.
module irq_edge_pend #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] rise,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    // Edge detect against the value from the previous cycle.
    assign rise = req & ~req_q;

    // Remember the previous line level.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    // Set on an edge, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | rise;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (req[g] && !req_q[g]) |=> pend[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_order_fifo.sv
// Arrival-order queue of source ids, used for sequential handling.
// Assumes: the caller masks out any source that is already pending, so the
// queue holds each source at most once and never needs more than N slots.
// When it pops and appends in the same cycle, the pop happens first.
// Edges in the same cycle are appended lowest index first.
module irq_order_fifo #(
    parameter int N   = 3,
    parameter int IDW = 2,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   push_mask,
    input  logic           pop,
    output logic [IDW-1:0] head,
    output logic           empty
);
    logic [IDW-1:0] q   [N];
    logic [IDW-1:0] q_n [N];
    logic [CW-1:0]  cnt, cnt_n;

    assign head  = q[0];
    assign empty = (cnt == '0);

    // Next state: shift on pop, then append new arrivals in index order.
    always_comb begin
        q_n   = q;
        cnt_n = cnt;
        if (pop && cnt != '0) begin
            for (int k = 0; k < N - 1; k++) q_n[k] = q[k+1];
            q_n[N-1] = '0;
            cnt_n    = cnt - 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (push_mask[i] && cnt_n < CW'(N)) begin
                q_n[cnt_n[IDW-1:0]] = IDW'(i);
                cnt_n = cnt_n + 1'b1;
            end
        end
    end

    // Queue storage and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) q[k] <= '0;
            cnt <= '0;
        end else begin
            q   <= q_n;
            cnt <= cnt_n;
        end
    end

    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(N));
endmodule

// File: rtl/irq_svc_stack.sv
// Stack of the sources in service; the top entry is the active one.
// Assumes: a push is only requested for a source that outranks the top
// (nested) or when the stack is empty (sequential), so depth N is enough.
// A pop and a push in the same cycle replace the top entry.
module irq_svc_stack #(
    parameter int N   = 3,
    parameter int IDW = 2,
    parameter int CW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic           top_valid,
    output logic [IDW-1:0] top_id,
    output logic           full
);
    logic [IDW-1:0] mem [N];
    logic [CW-1:0]  sp;
    logic [CW-1:0]  sp_m1;
    logic           pop_eff;

    assign sp_m1     = sp - 1'b1;
    assign top_valid = (sp != '0);
    assign full      = (sp == CW'(N));
    assign top_id    = top_valid ? mem[sp_m1[IDW-1:0]] : '0;
    assign pop_eff   = pop && top_valid;

    // Update the stack pointer and the entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int k = 0; k < N; k++) mem[k] <= '0;
        end else if (pop_eff && push) begin
            mem[sp_m1[IDW-1:0]] <= push_id;
        end else if (pop_eff) begin
            sp <= sp_m1;
        end else if (push && !full) begin
            mem[sp[IDW-1:0]] <= push_id;
            sp <= sp + 1'b1;
        end
    end

    a_r9_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_eff && !push) |=> (sp == $past(sp) - 1'b1));
    a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop_eff));
endmodule

// File: rtl/irq_nest_ctrl.sv
// Interrupt controller with a sequential (arrival order) and a nested
// (priority preemption) policy.
// Assumes: mode_nested changes only while nothing is pending or in service,
// and the processor acknowledges only while irq_req is high.
// SRC_PRIO packs one level per source, with source 0 in the low bits.
module irq_nest_ctrl
    import irq_pkg::*;
#(
    parameter int                   N_SRC    = 3,
    parameter int                   PRIO_W   = 3,
    parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO = {3'd5, 3'd4, 3'd2},
    localparam int                  IDW      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int                  CW       = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             mode_nested,
    output logic             irq_req,
    output logic [IDW-1:0]   irq_id,
    input  logic             irq_ack,
    input  logic             svc_done,
    output logic             active_valid,
    output logic [IDW-1:0]   active_id
);
    irq_policy_e         policy;
    logic [N_SRC-1:0]    rise, pend, clr_mask, push_mask;
    logic                ack_fire;
    logic [IDW-1:0]      fifo_head;
    logic                fifo_empty, fifo_pop, head_live;
    logic                seq_valid;
    logic                best_v, nest_valid;
    logic [IDW-1:0]      best_id;
    logic [PRIO_W-1:0]   best_p, top_p;
    logic                stk_full;

    // Level of a source, read from the packed parameter.
    function automatic logic [PRIO_W-1:0] level_of(input logic [IDW-1:0] id);
        return SRC_PRIO[id*PRIO_W +: PRIO_W];
    endfunction

    assign policy   = mode_nested ? POL_NEST : POL_SEQ;
    assign ack_fire = irq_ack && irq_req;

    // One-hot clear for the source that was just acknowledged.
    always_comb begin
        clr_mask = '0;
        if (ack_fire) clr_mask[irq_id] = 1'b1;
    end

    // Queue a new arrival unless the source is already waiting.
    assign push_mask = rise & (~pend | clr_mask);

    irq_edge_pend #(.N(N_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(src_req), .clr_mask(clr_mask),
        .rise(rise), .pend(pend)
    );

    // Drop the head once it is served, or when its source is no longer pending.
    assign head_live = !fifo_empty && pend[fifo_head];
    assign fifo_pop  = !fifo_empty && (!pend[fifo_head] ||
                       (ack_fire && irq_id == fifo_head));

    irq_order_fifo #(.N(N_SRC), .IDW(IDW), .CW(CW)) u_order (
        .clk(clk), .rst_n(rst_n), .push_mask(push_mask), .pop(fifo_pop),
        .head(fifo_head), .empty(fifo_empty)
    );

    irq_svc_stack #(.N(N_SRC), .IDW(IDW), .CW(CW)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(ack_fire), .push_id(irq_id),
        .pop(svc_done), .top_valid(active_valid), .top_id(active_id),
        .full(stk_full)
    );

    // Sequential candidate: the oldest live arrival, only when idle.
    assign seq_valid = !active_valid && head_live;

    // Nested candidate: the most urgent pending source, lowest index on a tie.
    always_comb begin
        best_v  = 1'b0;
        best_id = '0;
        best_p  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (!best_v || level_of(IDW'(i)) > best_p)) begin
                best_v  = 1'b1;
                best_id = IDW'(i);
                best_p  = level_of(IDW'(i));
            end
        end
    end

    assign top_p      = level_of(active_id);
    assign nest_valid = best_v && (!active_valid || best_p > top_p);

    // Pick the offer according to the policy in force.
    always_comb begin
        if (policy == POL_NEST) begin
            irq_req = nest_valid;
            irq_id  = best_id;
        end else begin
            irq_req = seq_valid;
            irq_id  = fifo_head;
        end
    end

    a_r4_seq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_SEQ && active_valid) |-> !irq_req);
    a_r8_nest_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_NEST && irq_req && active_valid) |->
            (level_of(irq_id) > level_of(active_id)));
    a_r3_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !svc_done) |=> (active_valid && active_id == $past(irq_id)));
    a_r11_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && !active_valid && !ack_fire) |=> !active_valid);
    a_r3_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> pend[irq_id]);
endmodule

// File: tb/irq_nest_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_nest_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_req = '0;
    logic       mode_nested = 1'b0;
    logic       irq_ack = 1'b0;
    logic       svc_done = 1'b0;
    logic       irq_req, active_valid;
    logic [1:0] irq_id, active_id;

    int checks = 0;
    int failures = 0;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .mode_nested(mode_nested),
        .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack),
        .svc_done(svc_done), .active_valid(active_valid), .active_id(active_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(logic nested);
        rst_n = 1'b0; src_req = '0; irq_ack = 0; svc_done = 0;
        mode_nested = nested;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // Raise the chosen lines for one cycle, then drop them.
    task automatic pulse(logic [2:0] m);
        src_req = src_req | m;
        step();
        src_req = src_req & ~m;
    endtask

    task automatic ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic done();
        svc_done = 1'b1; step(); svc_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 irq_req", int'(irq_req), 0);
        check("R1 active_valid", int'(active_valid), 0);
    endtask

    task automatic t_seq_order();
        do_reset(1'b0);
        pulse(3'b100);
        check("R3 offer", int'(irq_req), 1);
        check("R3 offer id", int'(irq_id), 2);
        ack();
        check("R3 active_id", int'(active_id), 2);
        pulse(3'b001);
        pulse(3'b010);
        check("R4 quiet in service", int'(irq_req), 0);
        done();
        check("R5 first arrival", int'(irq_id), 0);
        check("R5 offered", int'(irq_req), 1);
        ack(); done();
        check("R5 second arrival", int'(irq_id), 1);
        ack(); done();
        check("R5 drained", int'(irq_req), 0);
    endtask

    task automatic t_seq_dup();
        do_reset(1'b0);
        pulse(3'b100); ack();
        pulse(3'b001); step();
        pulse(3'b001);
        pulse(3'b010);
        done();
        check("R6 first id", int'(irq_id), 0);
        ack(); done();
        check("R6 second id", int'(irq_id), 1);
        ack(); done();
        check("R6 served once", int'(irq_req), 0);
        pulse(3'b011);
        check("R5 same-cycle lowest first", int'(irq_id), 0);
    endtask

    task automatic t_nested();
        do_reset(1'b1);
        pulse(3'b001); ack();
        check("R3 active 0", int'(active_id), 0);
        pulse(3'b010);
        check("R7 preempt by 1", int'(irq_req), 1);
        check("R7 preempt id", int'(irq_id), 1);
        ack();
        pulse(3'b100);
        check("R7 preempt by 2", int'(irq_id), 2);
        ack();
        check("R3 active 2", int'(active_id), 2);
        pulse(3'b010);
        check("R8 lower waits", int'(irq_req), 0);
        done();
        check("R9 back to 1", int'(active_id), 1);
        check("R8 equal waits", int'(irq_req), 0);
        done();
        check("R9 back to 0", int'(active_id), 0);
        check("R7 waiting 1 now offered", int'(irq_id), 1);
        ack(); done();
        check("R9 return 0 again", int'(active_id), 0);
        done();
        check("R9 stack empty", int'(active_valid), 0);
    endtask

    task automatic t_prio_idle();
        do_reset(1'b1);
        pulse(3'b011);
        check("R10 level 4 over 2", int'(irq_id), 1);
        ack(); done();
        check("R10 remaining 0", int'(irq_id), 0);
        ack(); done();
        pulse(3'b101);
        check("R10 level 5 over 2", int'(irq_id), 2);
    endtask

    task automatic t_ignored();
        do_reset(1'b0);
        ack();
        check("R11 stray ack", int'(active_valid), 0);
        done();
        check("R11 stray done", int'(active_valid), 0);
        check("R11 no offer", int'(irq_req), 0);
        src_req = 3'b010; step();
        ack(); done();
        check("R2 level held no retrigger", int'(irq_req), 0);
        src_req = '0; step();
    endtask

    initial begin
        t_reset();
        t_seq_order();
        t_seq_dup();
        t_nested();
        t_prio_idle();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule